// File: doc/BRIEF.md
# Dual-Mode Digital Phase Detector

This block compares a reference square wave with a feedback square wave from an oscillator, both sampled on a fast system clock. A mode input chooses the comparison method. In exclusive-OR mode the error output is high whenever the two inputs differ, so its duty cycle grows with their phase difference. In latch mode a set-reset latch is raised by the reference and dropped by the feedback. The latch is level-sensitive and the set input wins, so a long reference pulse holds the error high whatever the feedback does.

Both inputs pass through two-flop synchronisers before they are compared. A measurement stage counts system-clock cycles between consecutive feedback rising edges and, inside that window, the cycles in which the error output was high. At each feedback rising edge it reports both counts with a one-cycle valid strobe. The period and high counts can then be used as a phase-difference word for a digital loop filter.

Top module: `phase_detector_dual`

## Requirements
- R1: With `mode_sel`=0 (exclusive-OR mode), `err_out` equals the XOR of `ref_in` and `fb_in`, delayed by three clock edges (two synchroniser flops and one output register).
- R2: In exclusive-OR mode, identical inputs keep `err_out` low over the whole feedback period (high count 0), and inverted inputs keep it high (high count equal to the period).
- R3: In exclusive-OR mode, a feedback square wave of period 8 gives a high count of 4 per period both with an equal-frequency reference 90 degrees away and with an aligned reference at twice the frequency.
- R4: With `mode_sel`=1 (latch mode), a high synchronised reference sets `err_out` and a high synchronised feedback with the reference low clears it; with neither high the output holds.
- R5: In latch mode, set dominates: when both synchronised inputs are high the output goes high, and a reference held high keeps `err_out` high for every cycle whatever the feedback pulses.
- R6: In latch mode, a one-cycle reference pulse just before each feedback rising edge of a 50% square wave gives a high count below half the period.
- R7: At each report, `period_cnt` equals the number of clock cycles since the previous report and `high_cnt` equals the number of those cycles in which `err_out` was high; both counters saturate at their maximum.
- R8: `meas_valid` pulses for exactly one cycle per synchronised feedback rising edge and is never high in two consecutive cycles.
- R9: A synchronous active-low reset clears `err_out`, `meas_valid`, `period_cnt`, `high_cnt` and the latch state at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the compared signals |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 0 = exclusive-OR detector, 1 = set-dominant latch detector |
| ref_in | input | 1 | Asynchronous reference signal |
| fb_in | input | 1 | Asynchronous feedback signal from the oscillator |
| err_out | output | 1 | Registered phase error output |
| period_cnt | output | CNT_W | Cycles in the last feedback period |
| high_cnt | output | CNT_W | Cycles with `err_out` high in the last feedback period |
| meas_valid | output | 1 | One-cycle strobe when new counts are presented |

## Verification
An input change seen at one falling clock edge shows on `err_out` three clock edges later, so the bench keeps a three-deep history of sampled inputs and compares `err_out` at each falling edge against an expectation built from the oldest entry, the mode seen one cycle earlier and the previous expectation. The measurement results appear one edge after the window closes; the bench accumulates its own period and high counts from `err_out` samples and compares them whenever `meas_valid` is seen, discarding the first report after reset because that window starts at reset release. Directed periodic patterns run for five feedback periods before the last reported counts are checked, so the compared window is in steady state.

// File: rtl/pd_pkg.sv
// Shared types for the dual-mode phase detector.
package pd_pkg;
    typedef enum logic {
        PD_MODE_XOR   = 1'b0,
        PD_MODE_LATCH = 1'b1
    } pd_mode_e;
endpackage

// File: rtl/pd_sync.sv
// pd_sync: multi-flop synchroniser for a bus of independent single-bit
// asynchronous signals. Assumes each bit may be sampled on its own; no
// coherence between bits is promised. Output resets to zero.
module pd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pd_compare.sv
// pd_compare: the two comparison methods and the registered error output.
// Assumes ref_s and fb_s are already synchronous to clk. The mode input
// is quasi-static configuration and is used directly.
module pd_compare
    import pd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pd_mode_e mode,
    input  logic     ref_s,
    input  logic     fb_s,
    output logic     err_q
);
    // Compute the next error value for the selected method.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            unique case (mode)
                PD_MODE_XOR:   err_q <= ref_s ^ fb_s;
                PD_MODE_LATCH: begin
                    if (ref_s)      err_q <= 1'b1;
                    else if (fb_s)  err_q <= 1'b0;
                end
                default:       err_q <= 1'b0;
            endcase
        end
    end

    // R5
    set_dominance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PD_MODE_LATCH && ref_s) |=> err_q);
    // R4
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PD_MODE_LATCH && fb_s && !ref_s) |=> !err_q);
    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PD_MODE_LATCH && !fb_s && !ref_s) |=> $stable(err_q));
    // R1
    xor_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PD_MODE_XOR && ref_s == fb_s) |=> !err_q);
endmodule

// File: rtl/pd_duty.sv
// pd_duty: measures the error high-time over each feedback period.
// Assumes fb_s is synchronous to clk. Counters saturate rather than wrap.
// Reports at the cycle after a feedback rising edge is seen.
module pd_duty #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fb_s,
    input  logic             err,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] high_o,
    output logic             valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             fb_d;
    logic [CNT_W-1:0] per_acc;
    logic [CNT_W-1:0] hi_acc;
    logic [CNT_W-1:0] per_next;
    logic [CNT_W-1:0] hi_next;
    logic             fb_rise;

    // Saturating totals including the current cycle.
    always_comb begin
        per_next = (per_acc == CNT_MAX) ? CNT_MAX : per_acc + 1'b1;
        hi_next  = (err && hi_acc != CNT_MAX) ? hi_acc + 1'b1 : hi_acc;
        fb_rise  = fb_s && !fb_d;
    end

    // Accumulate within a period, report and restart on a feedback rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_d     <= 1'b0;
            per_acc  <= '0;
            hi_acc   <= '0;
            period_o <= '0;
            high_o   <= '0;
            valid_o  <= 1'b0;
        end else begin
            fb_d    <= fb_s;
            valid_o <= fb_rise;
            if (fb_rise) begin
                period_o <= per_next;
                high_o   <= hi_next;
                per_acc  <= '0;
                hi_acc   <= '0;
            end else begin
                per_acc  <= per_next;
                hi_acc   <= hi_next;
            end
        end
    end

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R7
    high_le_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (high_o <= period_o));
    // R7
    report_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_rise |=> $stable(period_o) && $stable(high_o));
endmodule

// File: rtl/phase_detector_dual.sv
// phase_detector_dual: synchronises reference and feedback, compares them
// by XOR or set-dominant latch, and measures the error duty per feedback
// period. Assumes clk is much faster than either compared signal.
module phase_detector_dual
    import pd_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic             err_out,
    output logic [CNT_W-1:0] period_cnt,
    output logic [CNT_W-1:0] high_cnt,
    output logic             meas_valid
);
    logic [1:0] sync_q;
    pd_mode_e   mode;

    assign mode = pd_mode_e'(mode_sel);

    pd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ref_in, fb_in}),
        .q     (sync_q)
    );

    pd_compare u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .ref_s (sync_q[1]),
        .fb_s  (sync_q[0]),
        .err_q (err_out)
    );

    pd_duty #(.CNT_W(CNT_W)) u_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .fb_s     (sync_q[0]),
        .err      (err_out),
        .period_o (period_cnt),
        .high_o   (high_cnt),
        .valid_o  (meas_valid)
    );

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!err_out && !meas_valid && period_cnt == '0 && high_cnt == '0));
endmodule

// File: tb/phase_detector_dual_bench.sv
module phase_detector_dual_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;
    localparam int WDOG       = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_sel = 1'b0;
    logic             ref_in = 1'b0;
    logic             fb_in = 1'b0;
    logic             err_out;
    logic [CNT_W-1:0] period_cnt;
    logic [CNT_W-1:0] high_cnt;
    logic             meas_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_detector_dual #(.CNT_W(CNT_W)) u_phase_detector_dual (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .ref_in(ref_in), .fb_in(fb_in), .err_out(err_out),
        .period_cnt(period_cnt), .high_cnt(high_cnt), .meas_valid(meas_valid)
    );

    // Generic check reporter.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected error per requirement R1 / R4 / R5.
    function automatic bit next_err(input bit mode, input bit r, input bit f, input bit prev);
        if (!mode) return r ^ f;
        if (r) return 1'b1;
        if (f) return 1'b0;
        return prev;
    endfunction

    // Model state, sampled at falling edges.
    bit h_ref [3];
    bit h_fb  [3];
    bit mode_prev = 0;
    bit exp_prev = 0;
    int settle = 0;
    int acc_p = 0, acc_h = 0;
    bit seen_first = 0;
    bit valid_prev = 0;
    int last_p = 0, last_h = 0;

    always @(negedge clk) begin
        bit e;
        if (!rst_n) begin
            settle = 0;
            for (int i = 0; i < 3; i++) begin h_ref[i] = 0; h_fb[i] = 0; end
            exp_prev = 0; acc_p = 0; acc_h = 0; seen_first = 0; valid_prev = 0;
            mode_prev = mode_sel;
        end else begin
            settle++;
            e = next_err(mode_prev, h_ref[2], h_fb[2], exp_prev);
            if (settle >= 4) begin
                if (mode_prev) check("R4 latch err", err_out, e);
                else           check("R1 xor err", err_out, e);
            end
            if (meas_valid) begin
                if (valid_prev) check("R8 valid width", 1, 0);
                if (seen_first) begin
                    check("R7 period", period_cnt, acc_p);
                    check("R7 high", high_cnt, acc_h);
                end
                last_p = period_cnt; last_h = high_cnt;
                seen_first = 1; acc_p = 0; acc_h = 0;
            end
            valid_prev = meas_valid;
            acc_p++;
            acc_h += err_out;
            h_ref[2] = h_ref[1]; h_ref[1] = h_ref[0]; h_ref[0] = ref_in;
            h_fb[2]  = h_fb[1];  h_fb[1]  = h_fb[0];  h_fb[0]  = fb_in;
            mode_prev = mode_sel;
            exp_prev = e;
        end
    end

    // Drive periodic reference and feedback patterns.
    task automatic drive_pat(input bit m, input int rp, input int rh, input int ro,
                             input int fp, input int fh, input int cycles);
        for (int t = 0; t < cycles; t++) begin
            @(posedge clk); #1;
            mode_sel = m;
            ref_in = ((t + ro) % rp) < rh;
            fb_in  = (t % fp) < fh;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 0; ref_in = 0; fb_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 err reset", err_out, 0);
        check("R9 valid reset", meas_valid, 0);
        check("R9 period reset", period_cnt, 0);
        check("R9 high reset", high_cnt, 0);
        @(posedge clk); #1;
        rst_n = 1;
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R2 identical inputs, then inverted inputs
        drive_pat(0, 8, 4, 0, 8, 4, 40);
        check("R2 in-phase high", last_h, 0);
        check("R2 in-phase period", last_p, 8);
        drive_pat(0, 8, 4, 4, 8, 4, 40);
        check("R2 antiphase high", last_h, 8);

        // R3 quadrature equal frequency, then double-frequency reference
        drive_pat(0, 8, 4, 2, 8, 4, 40);
        check("R3 quadrature high", last_h, 4);
        drive_pat(0, 4, 2, 0, 8, 4, 40);
        check("R3 double-freq high", last_h, 4);
        check("R3 double-freq period", last_p, 8);

        // R4 latch: set mid-period, cleared by next feedback rise
        drive_pat(1, 8, 1, 4, 8, 4, 40);
        check("R4 latch high", last_h, 4);

        // R5 reference held high
        drive_pat(1, 8, 8, 0, 8, 4, 40);
        check("R5 long ref high", last_h, 8);
        check("R5 err held", err_out, 1);

        // R6 narrow reference pulse before feedback rise
        drive_pat(1, 8, 1, 1, 8, 4, 40);
        check("R6 narrow high", last_h, 1);
        check("R6 below half", (2 * last_h < last_p) ? 1 : 0, 1);

        // Random stimulus in both modes; model checks R1, R4, R5, R7, R8
        for (int seg = 0; seg < 40; seg++) begin
            bit m = $urandom_range(0, 1);
            for (int t = 0; t < 200; t++) begin
                @(posedge clk); #1;
                mode_sel = m;
                if ($urandom_range(0, 3) == 0) ref_in = ~ref_in;
                if ($urandom_range(0, 4) == 0) fb_in = ~fb_in;
            end
        end

        // R9 reset after activity
        do_reset();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end
endmodule